// File: doc/BRIEF.md
# DAC Buffer Interrupt Flag Controller

This block sits between a register bus and a digital-to-analog converter. Software writes a sample into a one-entry holding buffer. A start-conversion event then moves the held sample into the active data register that drives the converter. If the event arrives while nothing is held, the event is recorded as an underrun and the output keeps its old value.

Three sticky status flags report what happened: a held sample was consumed, an underrun occurred, or a synchronized register write has settled. The flags live in an 8-bit register that software clears by writing ones. A shared enable register masks them onto one interrupt request line. The enable register has separate set and clear addresses.

Writes to the control register and to the holding buffer start a fixed-length busy period, which stands in for a write crossing a clock domain. The settle flag is raised only when a busy period started by a buffer write ends. It is not raised when the busy period came from an enable change or a soft reset.

Top module: `dac_irq_flag_ctrl`

## Requirements
- R1: After reset the flag register, the enable register, the run bit, the holding buffer, the active data output, the busy status and `irq` are all zero, and the buffer counts as empty.
- R2: The flag register reads at offset 0x6 with underrun at bit 0, buffer-consumed at bit 1 and write-settled at bit 2. Bits above bit 2 always read zero and writes to them change nothing.
- R3: Writing the flag register clears every flag whose written bit is one and leaves the flags written with zero unchanged. While `wr_lock` is high, a write to the flag register clears nothing.
- R4: A write to offset 0x2 stores the data in the holding buffer, marks the buffer full and clears the buffer-consumed flag. Offset 0x2 reads back the buffer and offset 0x3 reads back the active data.
- R5: A start-conversion event with the buffer full copies the buffer into `dac_data` on the same clock edge, marks the buffer empty and sets the buffer-consumed flag.
- R6: A start-conversion event with the buffer empty sets the underrun flag and leaves `dac_data` unchanged.
- R7: A write to offset 0x2 or to the control register at offset 0x0 makes the busy status (bit 0 at offset 0x7) read one for exactly BUSY_CYC cycles. A new such write restarts the count.
- R8: When a busy period ends, the write-settled flag sets only if the most recent write that started busy was a buffer write. An end that follows a control write (enable change or soft reset) sets nothing.
- R9: Writing ones at offset 0x5 sets enable bits and writing ones at offset 0x4 clears them. Both offsets read the same 3-bit enable value, with enable bits placed at the same positions as the flags.
- R10: `irq` is high exactly when some flag is set and its enable bit is one.
- R11: When a hardware set condition and a software clear of the same flag fall on one cycle, the flag ends set.
- R12: A control write with bit 1 set is a soft reset. On the next edge it clears the flags, the enables, the run bit (control bit 0), the buffer and `dac_data`, marks the buffer empty, and starts busy. A start event in that same cycle is ignored.
- R13: A start event and a buffer write in the same cycle move the old buffer contents to `dac_data` and store the new data. The buffer stays full and the buffer-consumed flag does not set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W | Register offset for reads and writes |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data for the offset on `bus_addr` (combinational) |
| wr_lock | input | 1 | Write protection for the flag register |
| conv_evt | input | 1 | Start-conversion event, one cycle per event |
| dac_data | output | DATA_W | Active sample presented to the converter |
| irq | output | 1 | Interrupt request |

## Verification
The start event is driven against a full buffer, against an empty buffer, and on the same cycle as a buffer write. These three cases separate a real load, an underrun and the write-over-load ordering. Flag writes are driven with zeros, with only reserved bits, with `wr_lock` high, and on the same cycle as a hardware set. These show that clearing is selective, that the lock works, and that the set takes priority. Busy periods are started by a buffer write, by an enable write and by a soft reset. Only the first may leave the settle flag behind, which shows that the flag tracks the origin of the busy period and not just its end.

// File: rtl/dacf_pkg.sv
package dacf_pkg;
   // flag and enable bit positions (software decodes these)
   localparam int FB_UNDER = 0;
   localparam int FB_EMPTY = 1;
   localparam int FB_SYNC  = 2;
   localparam int NFLAGS   = 3;

   // register offsets
   localparam int OFS_CTRL   = 0;
   localparam int OFS_HOLD   = 2;
   localparam int OFS_ACTIVE = 3;
   localparam int OFS_EN_CLR = 4;
   localparam int OFS_EN_SET = 5;
   localparam int OFS_FLAGS  = 6;
   localparam int OFS_STAT   = 7;

   // control register bits
   localparam int CB_RUN  = 0;
   localparam int CB_SRST = 1;

   typedef enum logic [1:0] {
      SRC_NONE   = 2'd0,
      SRC_DATA   = 2'd1,
      SRC_ENABLE = 2'd2,
      SRC_RESET  = 2'd3
   } busy_src_e;
endpackage

// File: rtl/dacf_sync_timer.sv
module dacf_sync_timer
   import dacf_pkg::*;
#(
   parameter int BUSY_CYC = 4
) (
   input  logic      clk,
   input  logic      rst_n,
   input  logic      start,
   input  busy_src_e start_src,
   output logic      busy,
   output logic      data_done
);
   localparam int CW = $clog2(BUSY_CYC + 1);

   logic [CW-1:0] cnt_q;
   busy_src_e     src_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         src_q <= SRC_NONE;
      end else if (start) begin
         cnt_q <= CW'(BUSY_CYC);
         src_q <= start_src;
      end else if (cnt_q != '0) begin
         cnt_q <= cnt_q - CW'(1);
      end
   end

   assign busy      = (cnt_q != '0);
   assign data_done = (cnt_q == CW'(1)) && !start && (src_q == SRC_DATA);
endmodule

// File: rtl/dacf_buffer.sv
module dacf_buffer #(
   parameter int DATA_W = 12
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              flush,
   input  logic              wr,
   input  logic [DATA_W-1:0] wdata,
   input  logic              evt,
   output logic              full,
   output logic [DATA_W-1:0] hold_q,
   output logic [DATA_W-1:0] active_q,
   output logic              empty_set,
   output logic              under_set
);
   logic load;

   assign load = evt && full && !flush;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         full     <= 1'b0;
         hold_q   <= '0;
         active_q <= '0;
      end else if (flush) begin
         full     <= 1'b0;
         hold_q   <= '0;
         active_q <= '0;
      end else begin
         if (load)
            active_q <= hold_q;
         if (wr) begin
            hold_q <= wdata;
            full   <= 1'b1;
         end else if (load) begin
            full <= 1'b0;
         end
      end
   end

   assign empty_set = load && !wr;
   assign under_set = evt && !full && !flush;
endmodule

// File: rtl/dacf_flag_bank.sv
module dacf_flag_bank #(
   parameter int NF = 3
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          flush,
   input  logic [NF-1:0] set_v,
   input  logic [NF-1:0] clr_v,
   output logic [NF-1:0] flags
);
   for (genvar i = 0; i < NF; i++) begin : g_flag
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            flags[i] <= 1'b0;
         else if (flush)
            flags[i] <= 1'b0;
         else if (set_v[i])
            flags[i] <= 1'b1;
         else if (clr_v[i])
            flags[i] <= 1'b0;
      end
   end
endmodule

// File: rtl/dac_irq_flag_ctrl.sv
module dac_irq_flag_ctrl
   import dacf_pkg::*;
#(
   parameter int DATA_W   = 12,
   parameter int ADDR_W   = 3,
   parameter int BUSY_CYC = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   input  logic              wr_lock,
   input  logic              conv_evt,
   output logic [DATA_W-1:0] dac_data,
   output logic              irq
);
   if (DATA_W < 8)
      $error("dac_irq_flag_ctrl: DATA_W must be at least 8");
   if (ADDR_W < 3)
      $error("dac_irq_flag_ctrl: ADDR_W must be at least 3");
   if (BUSY_CYC < 1)
      $error("dac_irq_flag_ctrl: BUSY_CYC must be at least 1");

   localparam int PADF = DATA_W - NFLAGS;
   localparam int PAD1 = DATA_W - 1;

   logic wr_ctrl, wr_hold, wr_enclr, wr_enset, wr_flags, soft_rst;
   logic run_q;
   logic [NFLAGS-1:0] irq_en, flags, set_v, clr_v;
   logic buf_full, empty_set, under_set, busy, data_done;
   logic [DATA_W-1:0] hold_q;
   busy_src_e start_src;

   assign wr_ctrl  = bus_wr && (bus_addr == ADDR_W'(OFS_CTRL));
   assign wr_hold  = bus_wr && (bus_addr == ADDR_W'(OFS_HOLD));
   assign wr_enclr = bus_wr && (bus_addr == ADDR_W'(OFS_EN_CLR));
   assign wr_enset = bus_wr && (bus_addr == ADDR_W'(OFS_EN_SET));
   assign wr_flags = bus_wr && (bus_addr == ADDR_W'(OFS_FLAGS)) && !wr_lock;
   assign soft_rst = wr_ctrl && bus_wdata[CB_SRST];

   always_comb begin
      if (soft_rst)     start_src = SRC_RESET;
      else if (wr_ctrl) start_src = SRC_ENABLE;
      else              start_src = SRC_DATA;
   end

   dacf_sync_timer #(.BUSY_CYC(BUSY_CYC)) u_timer (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (wr_ctrl || wr_hold),
      .start_src (start_src),
      .busy      (busy),
      .data_done (data_done)
   );

   dacf_buffer #(.DATA_W(DATA_W)) u_buf (
      .clk       (clk),
      .rst_n     (rst_n),
      .flush     (soft_rst),
      .wr        (wr_hold),
      .wdata     (bus_wdata),
      .evt       (conv_evt),
      .full      (buf_full),
      .hold_q    (hold_q),
      .active_q  (dac_data),
      .empty_set (empty_set),
      .under_set (under_set)
   );

   always_comb begin
      set_v           = '0;
      set_v[FB_UNDER] = under_set;
      set_v[FB_EMPTY] = empty_set;
      set_v[FB_SYNC]  = data_done;
      clr_v           = wr_flags ? bus_wdata[NFLAGS-1:0] : '0;
      clr_v[FB_EMPTY] = clr_v[FB_EMPTY] | wr_hold;
   end

   dacf_flag_bank #(.NF(NFLAGS)) u_flags (
      .clk   (clk),
      .rst_n (rst_n),
      .flush (soft_rst),
      .set_v (set_v),
      .clr_v (clr_v),
      .flags (flags)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         irq_en <= '0;
         run_q  <= 1'b0;
      end else if (soft_rst) begin
         irq_en <= '0;
         run_q  <= 1'b0;
      end else begin
         if (wr_enset) irq_en <= irq_en | bus_wdata[NFLAGS-1:0];
         if (wr_enclr) irq_en <= irq_en & ~bus_wdata[NFLAGS-1:0];
         if (wr_ctrl)  run_q  <= bus_wdata[CB_RUN];
      end
   end

   assign irq = |(flags & irq_en);

   always_comb begin
      bus_rdata = '0;
      if      (bus_addr == ADDR_W'(OFS_CTRL))   bus_rdata = {{PAD1{1'b0}}, run_q};
      else if (bus_addr == ADDR_W'(OFS_HOLD))   bus_rdata = hold_q;
      else if (bus_addr == ADDR_W'(OFS_ACTIVE)) bus_rdata = dac_data;
      else if (bus_addr == ADDR_W'(OFS_EN_CLR) ||
               bus_addr == ADDR_W'(OFS_EN_SET)) bus_rdata = {{PADF{1'b0}}, irq_en};
      else if (bus_addr == ADDR_W'(OFS_FLAGS))  bus_rdata = {{PADF{1'b0}}, flags};
      else if (bus_addr == ADDR_W'(OFS_STAT))   bus_rdata = {{PAD1{1'b0}}, busy};
   end
endmodule

// File: rtl/dac_irq_flag_ctrl_chk.sv
module dac_irq_flag_ctrl_chk #(
   parameter int DATA_W = 12,
   parameter int ADDR_W = 3
) (
   input logic              clk,
   input logic              rst_n,
   input logic              bus_wr,
   input logic [ADDR_W-1:0] bus_addr,
   input logic [DATA_W-1:0] bus_wdata,
   input logic              wr_lock,
   input logic              conv_evt,
   input logic [DATA_W-1:0] dac_data,
   input logic              irq,
   input logic              buf_full,
   input logic [DATA_W-1:0] hold_q,
   input logic [2:0]        flags,
   input logic [2:0]        irq_en,
   input logic              busy
);
   logic srst, hold_wr, ctrl_wr, flag_wr_locked;
   assign ctrl_wr        = bus_wr && (bus_addr == ADDR_W'(0));
   assign srst           = ctrl_wr && bus_wdata[1];
   assign hold_wr        = bus_wr && (bus_addr == ADDR_W'(2));
   assign flag_wr_locked = bus_wr && (bus_addr == ADDR_W'(6)) && wr_lock;

   AST_UNDERRUN_SETS: assert property (@(posedge clk) disable iff (!rst_n)
      conv_evt && !buf_full && !srst |=> flags[0]); // R6
   AST_UNDERRUN_KEEPS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
      conv_evt && !buf_full && !srst |=> $stable(dac_data)); // R6
   AST_EVENT_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
      conv_evt && buf_full && !srst |=> dac_data == $past(hold_q)); // R5
   AST_HOLD_WRITE_FILLS: assert property (@(posedge clk) disable iff (!rst_n)
      hold_wr |=> buf_full && !flags[1]); // R4
   AST_BUSY_STARTS: assert property (@(posedge clk) disable iff (!rst_n)
      hold_wr || ctrl_wr |=> busy); // R7
   AST_MASKED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      irq_en == 3'b000 |-> !irq); // R10
   AST_SOFT_RESET_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      srst |=> flags == 3'b000 && irq_en == 3'b000 && !buf_full); // R12
   AST_LOCK_NO_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      flag_wr_locked |=> (flags & $past(flags)) == $past(flags)); // R3
endmodule

bind dac_irq_flag_ctrl dac_irq_flag_ctrl_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .bus_wr    (bus_wr),
   .bus_addr  (bus_addr),
   .bus_wdata (bus_wdata),
   .wr_lock   (wr_lock),
   .conv_evt  (conv_evt),
   .dac_data  (dac_data),
   .irq       (irq),
   .buf_full  (buf_full),
   .hold_q    (hold_q),
   .flags     (flags),
   .irq_en    (irq_en),
   .busy      (busy)
);

// File: tb/tb_dac_irq_flag_ctrl.sv
`timescale 1ns/1ps
module tb_dac_irq_flag_ctrl;
   localparam int DW = 12;
   localparam int AW = 3;
   localparam int BUSY = 4;

   logic          clk = 0;
   logic          rst_n = 0;
   logic          bus_wr = 0;
   logic [AW-1:0] bus_addr = '0;
   logic [DW-1:0] bus_wdata = '0;
   logic [DW-1:0] bus_rdata;
   logic          wr_lock = 0;
   logic          conv_evt = 0;
   logic [DW-1:0] dac_data;
   logic          irq;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   dac_irq_flag_ctrl #(.DATA_W(DW), .ADDR_W(AW), .BUSY_CYC(BUSY)) dut (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .wr_lock(wr_lock),
      .conv_evt(conv_evt), .dac_data(dac_data), .irq(irq));

   always #5 clk = ~clk;

   // behavioural reference state
   int m_flags, m_en, m_run, m_full, m_hold, m_data, m_left, m_from_data;

   always @(posedge clk) begin
      if (!rst_n) begin
         m_flags = 0; m_en = 0; m_run = 0; m_full = 0;
         m_hold = 0; m_data = 0; m_left = 0; m_from_data = 0;
      end else begin
         int a, d, setm, clrm;
         a = bus_wr ? int'(bus_addr) : -1;
         d = int'(bus_wdata);
         setm = 0; clrm = 0;
         if (a == 0 && d[1]) begin
            m_flags = 0; m_en = 0; m_run = 0; m_full = 0;
            m_hold = 0; m_data = 0; m_left = BUSY; m_from_data = 0;
         end else begin
            if (a == 0 || a == 2) begin
               m_left = BUSY; m_from_data = (a == 2);
            end else if (m_left > 0) begin
               if (m_left == 1 && m_from_data == 1) setm |= 4;
               m_left--;
            end
            if (conv_evt) begin
               if (m_full == 1) begin
                  m_data = m_hold;
                  if (a != 2) begin setm |= 2; m_full = 0; end
               end else setm |= 1;
            end
            if (a == 2) begin m_hold = d; m_full = 1; clrm |= 2; end
            if (a == 6 && !wr_lock) clrm |= d & 7;
            m_flags = (m_flags & ~clrm) | setm;
            if (a == 5) m_en |= d & 7;
            if (a == 4) m_en &= ~d & 7;
            if (a == 0) m_run = d & 1;
         end
      end
   end

   function automatic int exp_rd(int a);
      case (a)
         0: return m_run;
         2: return m_hold;
         3: return m_data;
         4, 5: return m_en;
         6: return m_flags;
         7: return (m_left > 0) ? 1 : 0;
         default: return 0;
      endcase
   endfunction

   task automatic chk(bit ok, string req, int act, int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: got 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   task automatic tick();
      @(negedge clk);
      chk(irq == ((m_flags & m_en) != 0), "R10 irq vs model", int'(irq), int'((m_flags & m_en) != 0));
      chk(int'(dac_data) == m_data, "R5 dac_data vs model", int'(dac_data), m_data);
      chk(int'(bus_rdata) == exp_rd(int'(bus_addr)), "R2 read vs model", int'(bus_rdata), exp_rd(int'(bus_addr)));
   endtask

   task automatic drive(bit w, int a, int d, bit e);
      bus_wr = w; bus_addr = AW'(a); bus_wdata = DW'(d); conv_evt = e;
      tick();
      bus_wr = 0; conv_evt = 0;
   endtask

   task automatic wr(int a, int d); drive(1, a, d, 0); endtask
   task automatic evt(); drive(0, 0, 0, 1); endtask
   task automatic idle(int n); for (int i = 0; i < n; i++) tick(); endtask

   task automatic rd(int a, int exp, string req);
      bus_addr = AW'(a);
      #1;
      chk(int'(bus_rdata) == exp, req, int'(bus_rdata), exp);
   endtask

   initial begin
      #2_000_000;
      if (!done) begin
         errors++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1;
      tick();
      // R1 reset state
      rd(6, 0, "R1 flags after reset");
      rd(5, 0, "R1 enables after reset");
      rd(7, 0, "R1 busy after reset");
      rd(2, 0, "R1 buffer after reset");
      chk(irq == 0, "R1 irq after reset", int'(irq), 0);
      chk(dac_data == 0, "R1 dac_data after reset", int'(dac_data), 0);
      // R6 underrun on empty buffer
      evt();
      rd(6, 1, "R6 underrun flag");
      chk(dac_data == 0, "R6 data unchanged", int'(dac_data), 0);
      // R9 / R10 enable
      wr(5, 1);
      rd(4, 1, "R9 enable via clear address");
      rd(5, 1, "R9 enable via set address");
      chk(irq == 1, "R10 irq on enabled flag", int'(irq), 1);
      // R3 / R2 clearing rules
      wr(6, 0);
      rd(6, 1, "R3 write zero no effect");
      wr_lock = 1; wr(6, 'hFF); wr_lock = 0;
      rd(6, 1, "R3 locked write ignored");
      wr(6, 'hF8);
      rd(6, 1, "R2 reserved bits ignored");
      wr(6, 1);
      rd(6, 0, "R3 write one clears");
      chk(irq == 0, "R10 irq drops", int'(irq), 0);
      // R4 / R7 / R8 buffer write and busy
      wr(2, 'h2A5);
      rd(2, 'h2A5, "R4 buffer readback");
      rd(7, 1, "R7 busy after write");
      idle(3);
      rd(7, 1, "R7 busy at last cycle");
      idle(1);
      rd(7, 0, "R7 busy ended");
      rd(6, 4, "R8 settle flag after buffer write");
      wr(6, 4);
      // R5 load
      evt();
      chk(dac_data == 'h2A5, "R5 load on event", int'(dac_data), 'h2A5);
      rd(3, 'h2A5, "R4 active readback");
      rd(6, 2, "R5 consumed flag");
      wr(2, 'h011);
      rd(6, 0, "R4 buffer write clears consumed");
      idle(5);
      wr(6, 7);
      // R11 set beats clear
      drive(1, 6, 2, 1);
      rd(6, 2, "R11 consumed set wins");
      chk(dac_data == 'h011, "R5 second load", int'(dac_data), 'h011);
      drive(1, 6, 1, 1);
      rd(6, 3, "R11 underrun set wins");
      wr(6, 3);
      // R13 event with simultaneous write
      wr(2, 'h100);
      idle(5);
      wr(6, 7);
      drive(1, 2, 'h0FF, 1);
      chk(dac_data == 'h100, "R13 old data moves out", int'(dac_data), 'h100);
      rd(6, 0, "R13 no consumed flag");
      rd(2, 'h0FF, "R13 new data held");
      evt();
      chk(dac_data == 'h0FF, "R13 buffer stayed full", int'(dac_data), 'h0FF);
      idle(5);
      wr(6, 7);
      // R8 enable write gives no settle flag
      wr(0, 1);
      rd(0, 1, "R8 run bit set");
      idle(6);
      rd(6, 0, "R8 no settle after enable write");
      // R9 / R10 masking
      wr(5, 7);
      rd(4, 7, "R9 set all enables");
      evt();
      chk(irq == 1, "R10 underrun raises irq", int'(irq), 1);
      wr(4, 5);
      rd(5, 2, "R9 clear selected enables");
      chk(irq == 0, "R10 masked flag quiet", int'(irq), 0);
      wr(6, 7);
      // R12 soft reset
      wr(2, 'h3FF);
      evt();
      wr(2, 'h3AA);
      wr(5, 7);
      wr(0, 2);
      rd(6, 0, "R12 flags cleared");
      rd(5, 0, "R12 enables cleared");
      rd(0, 0, "R12 run bit cleared");
      rd(7, 1, "R12 busy started");
      chk(dac_data == 0, "R12 data cleared", int'(dac_data), 0);
      idle(6);
      rd(6, 0, "R8 no settle after soft reset");
      evt();
      rd(6, 1, "R12 buffer emptied");
      idle(2);
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule